// File: doc/BRIEF.md
# Write-Acknowledge Readiness Tracker

This block sits on the consumer side of a data-exchange phase and turns returning write acknowledgments into readiness events. Software first loads a small associative table. Each table entry holds an address window and the consumer task that depends on that window. Software also loads a required row count for each task and the number of writes expected over the whole phase, then arms the block.

While the block is armed, each acknowledged address is compared against every table window in parallel. Every task named by a hit window advances its counter. When a task's counter reaches its required count, the block queues a readiness event for that task. A separate global counter advances on every accepted acknowledgment. When it reaches the expected total, the block raises a phase-complete pulse and disarms. A downstream scheduler consumes the events. No memory flags need to be polled.

Top module: `rdy_tracker`

## Requirements
- R1: An acknowledged address `a` hits a table entry when the entry is valid and `start <= a < end`. The start bound is included and the end bound is excluded.
- R2: Each acknowledgment adds at most one to the counter of any task, even when several valid entries naming that task are hit. One acknowledgment may advance several different tasks.
- R3: A task's counter reaching a nonzero required count causes `readyValid` to go high for exactly one cycle with `readyTask` equal to that task's index. A task whose required count is zero never produces an event.
- R4: A task produces at most one event per armed phase. Later hits on that task's windows in the same phase produce no further event.
- R5: Events are queued and leave at most one per cycle. The first event appears in the cycle after the completing acknowledgment. Tasks completed by the same acknowledgment leave on consecutive cycles in ascending index order.
- R6: The global counter advances on every accepted acknowledgment, whether or not it hits any entry. When the global count equals a nonzero expected total, `allReady` is high for exactly one cycle, in the cycle after that acknowledgment.
- R7: The `allReady` pulse disarms the block. Acknowledgments that arrive while the block is disarmed change no counter and produce no event and no `allReady` pulse.
- R8: An `armReq` pulse arms the block, zeroes every counter and discards queued events that have not yet been emitted. An acknowledgment presented in the same cycle as `armReq` is ignored.
- R9: After reset the block is disarmed, `readyValid` and `allReady` are low, and every table entry is invalid.
- R10: An entry written with its valid bit clear never hits, whatever its bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armReq | input | 1 | Start a new phase: arm, clear counters, flush events |
| cfgEntryWe | input | 1 | Write one table entry |
| cfgEntryIdx | input | EIW | Index of the table entry to write |
| cfgEntryValid | input | 1 | Valid bit of the written entry |
| cfgEntryStart | input | ADDR_W | Window start, inclusive |
| cfgEntryEnd | input | ADDR_W | Window end, exclusive |
| cfgEntryTask | input | TIW | Task that depends on the window |
| cfgTargetWe | input | 1 | Write one task's required count |
| cfgTargetIdx | input | TIW | Task index for the count write |
| cfgTargetRows | input | CNT_W | Required count; zero means the task never fires |
| cfgTotalWe | input | 1 | Write the expected total |
| cfgTotalWrites | input | TOTAL_W | Expected acknowledgments per phase; zero means no phase-complete pulse |
| ackValid | input | 1 | Write acknowledgment present |
| ackAddr | input | ADDR_W | Acknowledged address |
| readyValid | output | 1 | One-cycle task readiness event |
| readyTask | output | TIW | Task index carried by the event |
| allReady | output | 1 | One-cycle phase-complete pulse |

## Verification
The acknowledgment that completes the last expected write can also complete one or more tasks. The bench builds that case on purpose: one window is shared by every task and the expected total equals the number of acknowledgments sent. The first readiness event must then appear in the same cycle as `allReady`, and the remaining events must drain on the following cycles even though the block has already disarmed. The second overlap is arming while events are still queued, or while an acknowledgment is presented. This is provoked directly, and the bench judges it by the event stream going quiet and the counters restarting from zero.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

  // Strobes issued by the phase controller to the counting datapath.
  typedef struct packed {
    logic clearPhase;  // start of a new phase: zero counters, flush queue
    logic ackTake;     // an acknowledgment is accepted this cycle
  } rdyStrobes_t;

endpackage

// File: rtl/rdy_event_fifo.sv
module rdy_event_fifo #(
  parameter int NUM_TASKS = 4,
  parameter int TIW = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic [NUM_TASKS-1:0] pushVec,
  output logic                 outValid,
  output logic [TIW-1:0]       outTask
);

  localparam int PW = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1;
  localparam int DEPTH = 1 << PW;

  logic [TIW-1:0] slotMem [DEPTH];
  logic [PW-1:0]  rdPtr, wrPtr;
  logic [PW:0]    fillCnt;
  logic [PW:0]    pushCnt;
  logic [PW:0]    rank [NUM_TASKS];
  logic           popNow;

  // Each pushing task takes the slot after all lower-indexed pushers.
  always_comb begin
    logic [PW:0] acc;
    acc = '0;
    for (int t = 0; t < NUM_TASKS; t++) begin
      rank[t] = acc;
      acc = acc + {{PW{1'b0}}, pushVec[t]};
    end
    pushCnt = acc;
  end

  assign popNow   = (fillCnt != '0);
  assign outValid = popNow;
  assign outTask  = slotMem[rdPtr];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_TASKS; t++) begin
      if (pushVec[t] && !flush) begin
        slotMem[wrPtr + rank[t][PW-1:0]] <= TIW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fillCnt <= '0;
    end else begin
      wrPtr   <= wrPtr + pushCnt[PW-1:0];
      rdPtr   <= rdPtr + PW'(popNow);
      fillCnt <= fillCnt + pushCnt - (PW+1)'(popNow);
    end
  end

  // Each task enters at most once per phase, so the queue never overfills.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> ((fillCnt + pushCnt) <= (PW+1)'(DEPTH)));

  // A non-empty queue without new pushes shrinks by exactly one per cycle.
  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && popNow && pushVec == '0) |=> (fillCnt == $past(fillCnt) - 1'b1));

endmodule

// File: rtl/rdy_ctrl.sv
module rdy_ctrl
  import rdy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armReq,
  input  logic        ackValid,
  input  logic        globalHit,
  output rdyStrobes_t strobes,
  output logic        allReady
);

  logic armed;

  always_comb begin
    strobes.clearPhase = armReq;
    strobes.ackTake    = armed && ackValid && !armReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      allReady <= 1'b0;
    end else begin
      allReady <= globalHit;
      if (armReq) begin
        armed <= 1'b1;
      end else if (globalHit) begin
        armed <= 1'b0;
      end
    end
  end

  assert_all_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    allReady |=> !allReady);

  // Completion of the global count only happens on an accepted acknowledgment.
  assert_hit_needs_take_R6: assert property (@(posedge clk) disable iff (!rstN)
    globalHit |-> strobes.ackTake);

  assert_disarm_R7: assert property (@(posedge clk) disable iff (!rstN)
    allReady |-> !armed);

  assert_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (armed && !allReady));

endmodule

// File: rtl/rdy_datapath.sv
module rdy_datapath
  import rdy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_TASKS = 4,
  parameter int CNT_W = 8,
  parameter int TOTAL_W = 12,
  parameter int EIW = 3,
  parameter int TIW = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdyStrobes_t          strobes,
  input  logic                 cfgEntryWe,
  input  logic [EIW-1:0]       cfgEntryIdx,
  input  logic                 cfgEntryValid,
  input  logic [ADDR_W-1:0]    cfgEntryStart,
  input  logic [ADDR_W-1:0]    cfgEntryEnd,
  input  logic [TIW-1:0]       cfgEntryTask,
  input  logic                 cfgTargetWe,
  input  logic [TIW-1:0]       cfgTargetIdx,
  input  logic [CNT_W-1:0]     cfgTargetRows,
  input  logic                 cfgTotalWe,
  input  logic [TOTAL_W-1:0]   cfgTotalWrites,
  input  logic [ADDR_W-1:0]    ackAddr,
  output logic [NUM_TASKS-1:0] completeVec,
  output logic                 globalHit
);

  // Associative table
  logic              entValid [NUM_ENTRIES];
  logic [ADDR_W-1:0] entStart [NUM_ENTRIES];
  logic [ADDR_W-1:0] entEnd   [NUM_ENTRIES];
  logic [TIW-1:0]    entTask  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entryHit;

  // Per-task and global state
  logic [CNT_W-1:0]   taskTarget [NUM_TASKS];
  logic [CNT_W-1:0]   taskCnt    [NUM_TASKS];
  logic [CNT_W-1:0]   taskNext   [NUM_TASKS];
  logic [NUM_TASKS-1:0] taskDone;
  logic [NUM_TASKS-1:0] taskHit;
  logic [TOTAL_W-1:0] totalWrites;
  logic [TOTAL_W-1:0] globalCnt;
  logic [TOTAL_W-1:0] globalNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        entStart[e] <= '0;
        entEnd[e]   <= '0;
        entTask[e]  <= '0;
      end
    end else if (cfgEntryWe) begin
      entValid[cfgEntryIdx] <= cfgEntryValid;
      entStart[cfgEntryIdx] <= cfgEntryStart;
      entEnd[cfgEntryIdx]   <= cfgEntryEnd;
      entTask[cfgEntryIdx]  <= cfgEntryTask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TASKS; t++) taskTarget[t] <= '0;
      totalWrites <= '0;
    end else begin
      if (cfgTargetWe) taskTarget[cfgTargetIdx] <= cfgTargetRows;
      if (cfgTotalWe)  totalWrites <= cfgTotalWrites;
    end
  end

  // Parallel window compare, one comparator pair per entry.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    assign entryHit[e] = entValid[e] && (ackAddr >= entStart[e]) && (ackAddr < entEnd[e]);
  end

  // Fold entry hits onto tasks; several hits on one task count once.
  always_comb begin
    taskHit = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (entryHit[e]) taskHit[entTask[e]] = 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    assign taskNext[t] = taskCnt[t] + 1'b1;
    assign completeVec[t] = strobes.ackTake && taskHit[t] && !taskDone[t] &&
                            (taskTarget[t] != '0) && (taskNext[t] == taskTarget[t]);

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearPhase) begin
        taskCnt[t]  <= '0;
        taskDone[t] <= 1'b0;
      end else if (strobes.ackTake && taskHit[t] && !taskDone[t]) begin
        taskCnt[t] <= taskNext[t];
        if (completeVec[t]) taskDone[t] <= 1'b1;
      end
    end

    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      (taskDone[t] && !strobes.clearPhase) |=> taskDone[t]);

    assert_once_R4: assert property (@(posedge clk) disable iff (!rstN)
      taskDone[t] |-> !completeVec[t]);

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.clearPhase |=> (taskCnt[t] - $past(taskCnt[t])) <= CNT_W'(1));
  end

  assign globalNext = globalCnt + 1'b1;
  assign globalHit  = strobes.ackTake && (totalWrites != '0) && (globalNext == totalWrites);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearPhase) begin
      globalCnt <= '0;
    end else if (strobes.ackTake) begin
      globalCnt <= globalNext;
    end
  end

  assert_global_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackTake && !strobes.clearPhase) |=> (globalCnt == $past(globalCnt) + 1'b1));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.ackTake && !strobes.clearPhase) |=> ($stable(globalCnt) && $stable(taskDone)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearPhase |=> (globalCnt == '0 && taskDone == '0));

endmodule

// File: rtl/rdy_tracker.sv
module rdy_tracker
  import rdy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_TASKS = 4,
  parameter int CNT_W = 8,
  parameter int TOTAL_W = 12,
  localparam int EIW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int TIW = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armReq,
  input  logic               cfgEntryWe,
  input  logic [EIW-1:0]     cfgEntryIdx,
  input  logic               cfgEntryValid,
  input  logic [ADDR_W-1:0]  cfgEntryStart,
  input  logic [ADDR_W-1:0]  cfgEntryEnd,
  input  logic [TIW-1:0]     cfgEntryTask,
  input  logic               cfgTargetWe,
  input  logic [TIW-1:0]     cfgTargetIdx,
  input  logic [CNT_W-1:0]   cfgTargetRows,
  input  logic               cfgTotalWe,
  input  logic [TOTAL_W-1:0] cfgTotalWrites,
  input  logic               ackValid,
  input  logic [ADDR_W-1:0]  ackAddr,
  output logic               readyValid,
  output logic [TIW-1:0]     readyTask,
  output logic               allReady
);

  rdyStrobes_t          strobes;
  logic [NUM_TASKS-1:0] completeVec;
  logic                 globalHit;

  rdy_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .armReq    (armReq),
    .ackValid  (ackValid),
    .globalHit (globalHit),
    .strobes   (strobes),
    .allReady  (allReady)
  );

  rdy_datapath #(
    .ADDR_W      (ADDR_W),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_TASKS   (NUM_TASKS),
    .CNT_W       (CNT_W),
    .TOTAL_W     (TOTAL_W),
    .EIW         (EIW),
    .TIW         (TIW)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .cfgEntryWe     (cfgEntryWe),
    .cfgEntryIdx    (cfgEntryIdx),
    .cfgEntryValid  (cfgEntryValid),
    .cfgEntryStart  (cfgEntryStart),
    .cfgEntryEnd    (cfgEntryEnd),
    .cfgEntryTask   (cfgEntryTask),
    .cfgTargetWe    (cfgTargetWe),
    .cfgTargetIdx   (cfgTargetIdx),
    .cfgTargetRows  (cfgTargetRows),
    .cfgTotalWe     (cfgTotalWe),
    .cfgTotalWrites (cfgTotalWrites),
    .ackAddr        (ackAddr),
    .completeVec    (completeVec),
    .globalHit      (globalHit)
  );

  rdy_event_fifo #(
    .NUM_TASKS (NUM_TASKS),
    .TIW       (TIW)
  ) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.clearPhase),
    .pushVec  (completeVec),
    .outValid (readyValid),
    .outTask  (readyTask)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (!readyValid && !allReady));

endmodule

// File: tb/rdy_tracker_bench.sv
module rdy_tracker_bench;

  localparam int E = 8;
  localparam int T = 4;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int GW = 12;
  localparam int EIW = 3;
  localparam int TIW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armReq = 1'b0;
  logic cfgEntryWe = 1'b0;
  logic [EIW-1:0] cfgEntryIdx = '0;
  logic cfgEntryValid = 1'b0;
  logic [AW-1:0] cfgEntryStart = '0;
  logic [AW-1:0] cfgEntryEnd = '0;
  logic [TIW-1:0] cfgEntryTask = '0;
  logic cfgTargetWe = 1'b0;
  logic [TIW-1:0] cfgTargetIdx = '0;
  logic [CW-1:0] cfgTargetRows = '0;
  logic cfgTotalWe = 1'b0;
  logic [GW-1:0] cfgTotalWrites = '0;
  logic ackValid = 1'b0;
  logic [AW-1:0] ackAddr = '0;
  logic readyValid;
  logic [TIW-1:0] readyTask;
  logic allReady;

  always #2 clk = ~clk;

  rdy_tracker u_rdy_tracker (
    .clk(clk), .rstN(rstN), .armReq(armReq),
    .cfgEntryWe(cfgEntryWe), .cfgEntryIdx(cfgEntryIdx), .cfgEntryValid(cfgEntryValid),
    .cfgEntryStart(cfgEntryStart), .cfgEntryEnd(cfgEntryEnd), .cfgEntryTask(cfgEntryTask),
    .cfgTargetWe(cfgTargetWe), .cfgTargetIdx(cfgTargetIdx), .cfgTargetRows(cfgTargetRows),
    .cfgTotalWe(cfgTotalWe), .cfgTotalWrites(cfgTotalWrites),
    .ackValid(ackValid), .ackAddr(ackAddr),
    .readyValid(readyValid), .readyTask(readyTask), .allReady(allReady)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state, built from the requirements
  int mS[E]; int mE[E]; int mT[E]; bit mV[E];
  int mTgt[T]; int mCnt[T]; bit mDone[T];
  int mTot = 0; int mG = 0; bit mArmed = 0; bit expAll = 0;
  int mq[$];

  function automatic logic [T-1:0] matchTasks(int addr);
    logic [T-1:0] r = '0;
    for (int e = 0; e < E; e++)
      if (mV[e] && addr >= mS[e] && addr < mE[e]) r[mT[e]] = 1'b1;
    return r;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Compare outputs, advance the model for the upcoming edge, clock, idle inputs.
  task automatic cyc(string tag);
    bit expV;
    int expTask;
    logic [T-1:0] m;
    expV = (mq.size() > 0);
    expTask = expV ? mq[0] : 0;
    checks++;
    if (readyValid !== expV || (expV && readyTask !== TIW'(expTask)) || allReady !== expAll) begin
      failures++;
      $display("FAIL %s: readyValid=%0b readyTask=%0d allReady=%0b expected readyValid=%0b readyTask=%0d allReady=%0b",
               tag, readyValid, readyTask, allReady, expV, expTask, expAll);
    end
    if (armReq) begin
      mq.delete();
      for (int t = 0; t < T; t++) begin mCnt[t] = 0; mDone[t] = 0; end
      mG = 0; mArmed = 1; expAll = 0;
    end else begin
      if (mq.size() > 0) void'(mq.pop_front());
      expAll = 0;
      if (mArmed && ackValid) begin
        m = matchTasks(int'(ackAddr));
        for (int t = 0; t < T; t++) begin
          if (m[t] && !mDone[t]) begin
            mCnt[t]++;
            if (mTgt[t] != 0 && mCnt[t] == mTgt[t]) begin mDone[t] = 1; mq.push_back(t); end
          end
        end
        mG++;
        if (mTot != 0 && mG == mTot) begin expAll = 1; mArmed = 0; end
      end
    end
    if (cfgEntryWe) begin
      mV[cfgEntryIdx] = cfgEntryValid; mS[cfgEntryIdx] = int'(cfgEntryStart);
      mE[cfgEntryIdx] = int'(cfgEntryEnd); mT[cfgEntryIdx] = int'(cfgEntryTask);
    end
    if (cfgTargetWe) mTgt[cfgTargetIdx] = int'(cfgTargetRows);
    if (cfgTotalWe) mTot = int'(cfgTotalWrites);
    @(posedge clk);
    @(negedge clk);
    armReq = 0; cfgEntryWe = 0; cfgTargetWe = 0; cfgTotalWe = 0; ackValid = 0;
  endtask

  task automatic wrEntry(int idx, bit v, int s, int e, int tk);
    cfgEntryWe = 1; cfgEntryIdx = EIW'(idx); cfgEntryValid = v;
    cfgEntryStart = AW'(s); cfgEntryEnd = AW'(e); cfgEntryTask = TIW'(tk);
    cyc("cfg entry");
  endtask

  task automatic wrTarget(int idx, int rows);
    cfgTargetWe = 1; cfgTargetIdx = TIW'(idx); cfgTargetRows = CW'(rows);
    cyc("cfg target");
  endtask

  task automatic wrTotal(int n);
    cfgTotalWe = 1; cfgTotalWrites = GW'(n);
    cyc("cfg total");
  endtask

  task automatic doArm(string tag);
    armReq = 1;
    cyc(tag);
  endtask

  task automatic ack(int a, string tag);
    ackValid = 1; ackAddr = AW'(a);
    cyc(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    for (int e = 0; e < E; e++) begin mV[e] = 0; mS[e] = 0; mE[e] = 0; mT[e] = 0; end
    for (int t = 0; t < T; t++) begin mTgt[t] = 0; mCnt[t] = 0; mDone[t] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9: quiet outputs after reset; entries invalid so an unarmed table is empty
    idle(2, "R9 reset state");

    // R1 window bounds, R10 invalid entry
    wrEntry(0, 1, 16, 32, 0);
    wrEntry(1, 0, 0, 100, 1);
    wrTarget(0, 1); wrTarget(1, 1); wrTotal(0);
    doArm("R8 arm");
    ack(32, "R1 end bound excluded");
    ack(15, "R1 below start");
    ack(50, "R10 invalid entry never hits");
    ack(16, "R1 start bound included");
    idle(2, "R3 single pulse for task0");

    // R2 overlapping entries of one task count once; R4 once per phase
    wrEntry(2, 1, 100, 200, 2);
    wrEntry(3, 1, 150, 250, 2);
    wrTarget(2, 2);
    doArm("R8 arm");
    ack(160, "R2 double hit counts once");
    idle(1, "R2 no early event");
    ack(160, "R2 second ack completes task2");
    ack(170, "R4 no second event");
    idle(2, "R4 quiet after event");

    // R5 + R6: one ack completes every task and the phase
    wrEntry(0, 1, 300, 310, 0);
    wrEntry(4, 1, 300, 310, 1);
    wrEntry(2, 1, 300, 301, 2);
    wrEntry(5, 1, 305, 300, 3);
    wrEntry(6, 1, 299, 301, 3);
    for (int t = 0; t < T; t++) wrTarget(t, 1);
    wrTotal(3);
    doArm("R8 arm");
    ack(700, "R6 unmatched ack counts globally");
    ack(5000, "R6 unmatched ack counts globally");
    ack(300, "R5 R6 simultaneous completion");
    ack(300, "R7 ack after allReady ignored while draining");
    idle(4, "R5 ascending drain");

    // R7: disarmed block ignores a completing ack
    wrTarget(0, 2); wrTotal(1);
    doArm("R8 arm");
    ack(300, "R7 phase ends, task0 half way");
    ack(300, "R7 ignored after disarm");
    idle(5, "R7 no events while disarmed");

    // R8: arm flushes queued events and drops a same-cycle ack
    wrTarget(0, 1); wrTotal(0);
    doArm("R8 arm");
    ack(300, "R8 queue four events");
    idle(1, "R8 first event");
    doArm("R8 flush on arm");
    idle(2, "R8 queue empty after arm");
    armReq = 1; ackValid = 1; ackAddr = AW'(300);
    cyc("R8 ack with arm ignored");
    idle(2, "R8 no event from dropped ack");
    ack(300, "R8 counters restarted");
    idle(5, "R8 events again");

    // R3: zero target never fires
    wrTarget(3, 0);
    doArm("R8 arm");
    ack(300, "R3 zero target");
    ack(300, "R3 zero target");
    idle(5, "R3 no event for task3");

    // Constrained random phases
    for (int r = 0; r < 25; r++) begin
      for (int e = 0; e < E; e++) begin
        int s;
        s = int'($urandom_range(0, 400));
        wrEntry(e, ($urandom_range(0, 5) != 0), s, s + int'($urandom_range(0, 120)),
                int'($urandom_range(0, T-1)));
      end
      for (int t = 0; t < T; t++) wrTarget(t, int'($urandom_range(0, 5)));
      wrTotal(int'($urandom_range(0, 25)));
      doArm("R8 random arm");
      for (int i = 0; i < 50; i++) begin
        if ($urandom_range(0, 40) == 0) armReq = 1;
        if ($urandom_range(0, 2) != 0) begin
          ackValid = 1; ackAddr = AW'($urandom_range(0, 511));
        end
        cyc("R1 R2 R3 R4 R5 R6 R7 random phase");
      end
    end
    idle(6, "R5 final drain");
    summary();
  end

endmodule